// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This unit sits between an integer register file and a simple memory port and handles indexed loads and stores of byte, halfword and word size. Both plain and base-updating forms are supported. From a decoded command it forms the effective address, which is the B register value added to either the A register value or the constant zero. It issues one memory request and waits for the response. It then reports two register-file write requests in a single completion cycle: the formatted load result for the destination, and the effective address written back into the base register.

Bits are numbered big-endian, so bit 31 is the least significant bit of a 32-bit word. The narrow items therefore sit in the low-order end of the port vectors: bits 24..31 for a byte and bits 16..31 for a halfword, which are `[7:0]` and `[15:0]`. The base-update rule depends on the access type. An update load that names A index 0, or an A index equal to its destination, keeps its data write but drops the base write. An update store always writes the base, including register 0.

A command is accepted only when the unit is idle. From then on the request and the response each use their own valid/ready handshake, so exactly one access is in flight at any time.

Top module: `lsAddrUnit`

## Requirements
- R1: The memory address equals cmdValB plus cmdValA, or plus zero when cmdIdxA is 0, modulo 2^32.
- R2: A byte load (cmdSize = 0) returns memRspData[7:0] in wbDataVal[7:0] and zeros in every higher bit, whatever the value of cmdSigned.
- R3: A halfword load (cmdSize = 1) returns memRspData[15:0] in wbDataVal[15:0]. The upper 16 bits are zero when cmdSigned = 0, and copies of bit 15 when cmdSigned = 1.
- R4: A word load (cmdSize = 2) returns all 32 bits of memRspData unchanged.
- R5: A store drives memWrite = 1 and memSize = cmdSize. memWdata carries cmdValS[7:0], cmdValS[15:0] or all of cmdValS for sizes 0, 1 and 2, with zeros above the selected item. A load drives memWrite = 0.
- R6: An update load asserts wbBaseEn with wbBaseIdx = cmdIdxA and wbBaseVal = the effective address, unless cmdIdxA is 0 or cmdIdxA equals cmdIdxD. In those two cases wbBaseEn stays 0.
- R7: An update store asserts wbBaseEn with the effective address for every cmdIdxA, including 0.
- R8: With cmdUpdate = 0, wbBaseEn stays 0. Stores never assert wbDataEn.
- R9: cmdReady is high only while no access is in flight. memReqValid, memAddr and memWdata stay stable until memReqReady is seen.
- R10: Completion (doneValid, together with wbDataEn for loads and wbBaseEn) lasts exactly one cycle, in the cycle after the response handshake. Both write requests appear in that same cycle, and cmdReady returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit idle, command accepted |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdSize | input | 2 | 0 byte, 1 halfword, 2 word |
| cmdSigned | input | 1 | Sign-extend a halfword load |
| cmdUpdate | input | 1 | Write the address back into register A |
| cmdIdxA | input | 5 | Base register index |
| cmdIdxD | input | 5 | Destination (load) or source (store) index |
| cmdValA | input | 32 | Value of register A |
| cmdValB | input | 32 | Value of register B |
| cmdValS | input | 32 | Store source value |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memAddr | output | 32 | Effective address |
| memWrite | output | 1 | Request is a store |
| memSize | output | 2 | Access size |
| memWdata | output | 32 | Store data, low-justified |
| memRspValid | input | 1 | Memory response valid |
| memRspReady | output | 1 | Unit accepts response |
| memRspData | input | 32 | Load data, low-justified |
| doneValid | output | 1 | Completion cycle |
| wbDataEn | output | 1 | Destination write request |
| wbDataIdx | output | 5 | Destination index |
| wbDataVal | output | 32 | Formatted load result |
| wbBaseEn | output | 1 | Base write request |
| wbBaseIdx | output | 5 | Base index |
| wbBaseVal | output | 32 | Effective address written back |

## Verification
Two situations are hard to reach from the ports: an update load whose base and destination indices coincide, and an update store through register 0. In both, the data write and the base write must be judged in the same completion cycle. The bench sweeps every combination of load or store, size, signedness and update flag over three index relations (A index zero, A equal to D, A distinct). It also stretches the request and response handshakes with wait cycles, to show that the request holds steady and that completion stays a single cycle.

// File: rtl/lsau_pkg.sv
package lsau_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capCmd;
    logic capRsp;
    logic done;
  } ctrlStrobe_t;
endpackage

// File: rtl/lsau_ctrl.sv
module lsau_ctrl
  import lsau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        memRspReady,
  output logic        doneValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (cmdValid)    stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_RSP;
      ST_RSP:  if (memRspValid) stateNext = ST_DONE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady      = (state == ST_IDLE);
  assign memReqValid   = (state == ST_REQ);
  assign memRspReady   = (state == ST_RSP);
  assign doneValid     = (state == ST_DONE);
  assign strobe.capCmd = cmdReady & cmdValid;
  assign strobe.capRsp = memRspReady & memRspValid;
  assign strobe.done   = doneValid;

  // R9: one access at a time
  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !memReqValid && !memRspReady && !doneValid);
  // R9: an unaccepted request is held
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  // R10: completion follows the response handshake and lasts one cycle
  assert_done_after_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid && memRspReady |=> doneValid);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> cmdReady && !doneValid);
endmodule

// File: rtl/lsau_datapath.sv
module lsau_datapath
  import lsau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cmdIsStore,
  input  logic [1:0]        cmdSize,
  input  logic              cmdSigned,
  input  logic              cmdUpdate,
  input  logic [IDX_W-1:0]  cmdIdxA,
  input  logic [IDX_W-1:0]  cmdIdxD,
  input  logic [DATA_W-1:0] cmdValA,
  input  logic [DATA_W-1:0] cmdValB,
  input  logic [DATA_W-1:0] cmdValS,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrite,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbDataEn,
  output logic [IDX_W-1:0]  wbDataIdx,
  output logic [DATA_W-1:0] wbDataVal,
  output logic              wbBaseEn,
  output logic [IDX_W-1:0]  wbBaseIdx,
  output logic [DATA_W-1:0] wbBaseVal
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic              isStoreQ, signedQ, baseOkQ;
  accSize_e          sizeQ;
  logic [IDX_W-1:0]  idxAQ, idxDQ;
  logic [DATA_W-1:0] eaQ, wdataQ, rspQ;

  // operand A reads as zero for index 0
  logic [DATA_W-1:0] baseVal, eaNext, laneNext;
  assign baseVal = (cmdIdxA == '0) ? '0 : cmdValA;
  assign eaNext  = baseVal + cmdValB;

  always_comb begin
    unique case (accSize_e'(cmdSize))
      SZ_BYTE: laneNext = {{(DATA_W-BYTE_W){1'b0}}, cmdValS[BYTE_W-1:0]};
      SZ_HALF: laneNext = {{(DATA_W-HALF_W){1'b0}}, cmdValS[HALF_W-1:0]};
      default: laneNext = cmdValS;
    endcase
  end

  // base update: loads drop it for index 0 or A==D, stores keep it
  logic baseOkNext;
  assign baseOkNext = cmdUpdate &
                      (cmdIsStore | ((cmdIdxA != '0) & (cmdIdxA != cmdIdxD)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isStoreQ <= 1'b0;
      signedQ  <= 1'b0;
      baseOkQ  <= 1'b0;
      sizeQ    <= SZ_BYTE;
      idxAQ    <= '0;
      idxDQ    <= '0;
      eaQ      <= '0;
      wdataQ   <= '0;
    end else if (strobe.capCmd) begin
      isStoreQ <= cmdIsStore;
      signedQ  <= cmdSigned;
      baseOkQ  <= baseOkNext;
      sizeQ    <= accSize_e'(cmdSize);
      idxAQ    <= cmdIdxA;
      idxDQ    <= cmdIdxD;
      eaQ      <= eaNext;
      wdataQ   <= laneNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rspQ <= '0;
    else if (strobe.capRsp) rspQ <= memRspData;
  end

  // load formatting
  logic [DATA_W-1:0] loadFmt;
  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: loadFmt = {{(DATA_W-BYTE_W){1'b0}}, rspQ[BYTE_W-1:0]};
      SZ_HALF: loadFmt = {{(DATA_W-HALF_W){signedQ & rspQ[HALF_W-1]}},
                          rspQ[HALF_W-1:0]};
      default: loadFmt = rspQ;
    endcase
  end

  assign memAddr   = eaQ;
  assign memWrite  = isStoreQ;
  assign memSize   = sizeQ;
  assign memWdata  = wdataQ;
  assign wbDataEn  = strobe.done & ~isStoreQ;
  assign wbDataIdx = idxDQ;
  assign wbDataVal = loadFmt;
  assign wbBaseEn  = strobe.done & baseOkQ;
  assign wbBaseIdx = idxAQ;
  assign wbBaseVal = eaQ;

  // R8: write requests only in the completion cycle
  assert_wb_only_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbDataEn || wbBaseEn) |-> strobe.done);
  // R10: operands fixed between capture and completion
  assert_ops_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |-> $stable(eaQ) && $stable(idxAQ));
endmodule

// File: rtl/lsAddrUnit.sv
module lsAddrUnit
  import lsau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic        cmdIsStore,
  input  logic [1:0]  cmdSize,
  input  logic        cmdSigned,
  input  logic        cmdUpdate,
  input  logic [4:0]  cmdIdxA,
  input  logic [4:0]  cmdIdxD,
  input  logic [31:0] cmdValA,
  input  logic [31:0] cmdValB,
  input  logic [31:0] cmdValS,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memAddr,
  output logic        memWrite,
  output logic [1:0]  memSize,
  output logic [31:0] memWdata,
  input  logic        memRspValid,
  output logic        memRspReady,
  input  logic [31:0] memRspData,
  output logic        doneValid,
  output logic        wbDataEn,
  output logic [4:0]  wbDataIdx,
  output logic [31:0] wbDataVal,
  output logic        wbBaseEn,
  output logic [4:0]  wbBaseIdx,
  output logic [31:0] wbBaseVal
);
  ctrlStrobe_t strobe;

  lsau_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspReady(memRspReady),
    .doneValid(doneValid), .strobe(strobe)
  );

  lsau_datapath #(.DATA_W(32), .IDX_W(5)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdIsStore(cmdIsStore), .cmdSize(cmdSize), .cmdSigned(cmdSigned),
    .cmdUpdate(cmdUpdate), .cmdIdxA(cmdIdxA), .cmdIdxD(cmdIdxD),
    .cmdValA(cmdValA), .cmdValB(cmdValB), .cmdValS(cmdValS),
    .memRspData(memRspData), .memAddr(memAddr), .memWrite(memWrite),
    .memSize(memSize), .memWdata(memWdata),
    .wbDataEn(wbDataEn), .wbDataIdx(wbDataIdx), .wbDataVal(wbDataVal),
    .wbBaseEn(wbBaseEn), .wbBaseIdx(wbBaseIdx), .wbBaseVal(wbBaseVal)
  );

  // R9: pending request fields stay put
  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr) && $stable(memWdata));
  // R6: a load never writes base and data to the same register
  assert_no_same_port_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbDataEn && wbBaseEn |-> wbDataIdx != wbBaseIdx);
  // R7: stores never request a data write
  assert_store_no_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite && doneValid |-> !wbDataEn);
endmodule

// File: tb/sim_lsAddrUnit.sv
module sim_lsAddrUnit;
  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic cmdValid = 0, cmdReady, cmdIsStore = 0, cmdSigned = 0, cmdUpdate = 0;
  logic [1:0] cmdSize = 0, memSize;
  logic [4:0] cmdIdxA = 0, cmdIdxD = 0, wbDataIdx, wbBaseIdx;
  logic [31:0] cmdValA = 0, cmdValB = 0, cmdValS = 0, memAddr, memWdata;
  logic [31:0] memRspData = 0, wbDataVal, wbBaseVal;
  logic memReqValid, memReqReady = 0, memWrite, memRspValid = 0, memRspReady;
  logic doneValid, wbDataEn, wbBaseEn;

  lsAddrUnit u0 (.*);

  int nRun = 0, nFail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic st, input logic [1:0] sz, input logic sg,
                       input logic up, input logic [4:0] a, input logic [4:0] d,
                       input logic [31:0] va, input logic [31:0] vb,
                       input logic [31:0] vs, input logic [31:0] rsp,
                       input int reqWait, input int rspWait);
    logic [31:0] ea, expLoad, expLane;
    logic expBase;
    ea = ((a == 0) ? 32'h0 : va) + vb;
    case (sz)
      2'd0: begin expLoad = {24'h0, rsp[7:0]};  expLane = {24'h0, vs[7:0]}; end
      2'd1: begin expLoad = {{16{sg & rsp[15]}}, rsp[15:0]}; expLane = {16'h0, vs[15:0]}; end
      default: begin expLoad = rsp; expLane = vs; end
    endcase
    expBase = up && (st || (a != 0 && a != d));
    cmdIsStore = st; cmdSize = sz; cmdSigned = sg; cmdUpdate = up;
    cmdIdxA = a; cmdIdxD = d; cmdValA = va; cmdValB = vb; cmdValS = vs;
    cmdValid = 1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0; cmdValA = ~va; cmdValB = ~vb; cmdValS = ~vs;
    check("R9 cmdReady low in flight", {31'h0, cmdReady}, 32'h0);
    check("R9 memReqValid", {31'h0, memReqValid}, 32'h1);
    check("R1 memAddr", memAddr, ea);
    check("R5 memWrite", {31'h0, memWrite}, {31'h0, st});
    if (st) begin
      check("R5 memWdata", memWdata, expLane);
      check("R5 memSize", {30'h0, memSize}, {30'h0, sz});
    end
    for (int i = 0; i < reqWait; i++) begin
      @(negedge clk);
      check("R9 request held", {31'h0, memReqValid}, 32'h1);
      check("R9 address held", memAddr, ea);
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    for (int i = 0; i < rspWait; i++) begin
      check("R10 no early done", {31'h0, doneValid}, 32'h0);
      @(negedge clk);
    end
    memRspValid = 1; memRspData = rsp;
    @(negedge clk);
    memRspValid = 0; memRspData = 32'hdead_beef;
    check("R10 doneValid", {31'h0, doneValid}, 32'h1);
    check("R8 wbDataEn", {31'h0, wbDataEn}, {31'h0, ~st});
    if (!st) begin
      check(sz == 0 ? "R2 byte load" : sz == 1 ? "R3 half load" : "R4 word load",
            wbDataVal, expLoad);
      check("R10 wbDataIdx", {27'h0, wbDataIdx}, {27'h0, d});
    end
    check(st ? "R7 wbBaseEn store" : (up ? "R6 wbBaseEn load" : "R8 no update"),
          {31'h0, wbBaseEn}, {31'h0, expBase});
    if (expBase) begin
      check("R6 R7 wbBaseVal", wbBaseVal, ea);
      check("R6 R7 wbBaseIdx", {27'h0, wbBaseIdx}, {27'h0, a});
    end
    @(negedge clk);
    check("R10 single completion", {29'h0, doneValid, wbDataEn, wbBaseEn}, 32'h0);
    check("R10 cmdReady back", {31'h0, cmdReady}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [4:0] a, d;
    repeat (3) @(negedge clk);
    check("R9 reset cmdReady", {31'h0, cmdReady}, 32'h1);
    check("R10 reset idle", {28'h0, memReqValid, memRspReady, doneValid, wbBaseEn}, 32'h0);
    rstN = 1;
    @(negedge clk);
    for (int pat = 0; pat < 4; pat++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 3; sz++)
          for (int sg = 0; sg < 2; sg++)
            for (int up = 0; up < 2; up++)
              for (int rel = 0; rel < 3; rel++) begin
                d = 5'(3 + pat * 5 + sz);
                a = (rel == 0) ? 5'd0 : (rel == 1) ? d : 5'(d + 7);
                runOp(st[0], 2'(sz), sg[0], up[0], a, d,
                      $urandom(), (pat == 3) ? 32'hffff_fffc : $urandom(),
                      $urandom(),
                      (pat[0]) ? ($urandom() | 32'h0000_8080) : ($urandom() & 32'hffff_7f7f),
                      (rel + pat) % 3, (sz + pat) % 3);
              end
    // address wrap-around
    runOp(1'b0, 2'd2, 1'b0, 1'b1, 5'd4, 5'd9, 32'hffff_fff0, 32'h0000_0020,
          32'h0, 32'h1234_5678, 0, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule